// File: doc/BRIEF.md
# Stop-Mode Wake Qualifier

This block sits beside the interrupt controller and the clock controller and decides when a halted system may resume. When the CPU executes its stop instruction it raises a one-cycle stop request together with the kind of stop wanted. Full stop halts the external oscillator. Pseudo stop leaves the oscillator running. The block then holds a stop indicator and watches the pending events.

Events are a non-maskable external request and a set of maskable sources. Each maskable source brings a request line, an enable and a priority level. Whether a maskable source may end the stop depends on the CPU's global mask bit, on the level of the handler currently in service, and on the source's type, which is fixed by parameter. A general source follows the mask and level rules only. The real-time tick source also needs the oscillator to be running. A timer channel source can never wake the system.

When an event qualifies, the block emits a single-cycle wake pulse and drops the stop indicator on the same clock edge. If a qualified event is already pending when stop is requested, the stop is skipped and the block stays in run state. All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `wake_qualifier`

## Requirements
- R1: After reset `in_stop`, `wake` and `stop_pseudo` are all 0.
- R2: In run state, a `stop_req` pulse with no qualified event pending sets `in_stop` on the next clock edge. `stop_pseudo` follows `stop_kind` (1 = pseudo stop, 0 = full stop), latched at entry. A `stop_req` while already stopped has no effect.
- R3: While stopped, `nmi_req` ends the stop on the next edge from either stop kind, regardless of mask, level, enables and priorities.
- R4: While `cpu_mask` is 1, no maskable source can end the stop.
- R5: With `cpu_mask` 0, a maskable source ends the stop only if its priority is strictly greater than `isr_level`. A priority equal to `isr_level` does not wake.
- R6: A maskable source whose enable is 0, or whose priority is 0, never ends the stop.
- R7: A tick-type source ends the stop only from pseudo stop (source 4 by default).
- R8: A timer-type source never ends the stop and never prevents stop entry (source 3 by default).
- R9: An exit raises `wake` for exactly one cycle. `in_stop` and `stop_pseudo` fall on the same edge that raises `wake`.
- R10: If a qualified event is pending while `stop_req` is high in run state, the block stays in run state: `in_stop` stays 0 and no `wake` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle pulse from the stop instruction |
| stop_kind | input | 1 | Requested stop kind: 1 = pseudo stop, 0 = full stop |
| nmi_req | input | 1 | Non-maskable external request |
| src_req | input | NSRC | Maskable source request lines |
| src_en | input | NSRC | Per-source enables |
| src_prio | input | NSRC*PRIO_W | Per-source priority levels; source i uses bits [i*PRIO_W +: PRIO_W] |
| cpu_mask | input | 1 | CPU global mask bit for maskable requests |
| isr_level | input | PRIO_W | Priority level of the handler in service (0 = none) |
| wake | output | 1 | One-cycle wake pulse |
| in_stop | output | 1 | High while in a stop state |
| stop_pseudo | output | 1 | High while in pseudo stop |

## Verification
The hardest case to reach from the ports is a maskable request that is fully enabled and has a high priority but is still blocked. It can be blocked by the mask bit, by an equal in-service level, or by its source type under full stop. The bench first enters stop with no event pending. It then raises one such request and holds it for several cycles, and checks that `wake` stays low and `in_stop` stays high. Finally it lifts exactly one blocking condition, or uses the non-maskable request, to prove the block is still responsive. The skip path is reached by raising a qualified request before the stop pulse.

// File: rtl/wake_qual_pkg.sv
package wake_qual_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_STOP = 1'b1} wq_state_e;
  typedef enum logic [1:0] {
    SRC_GENERAL = 2'd0,
    SRC_TICK    = 2'd1,
    SRC_TIMER   = 2'd2
  } wq_src_kind_e;
endpackage

// File: rtl/wq_src_filter.sv
module wq_src_filter
  import wake_qual_pkg::*;
#(
  parameter int           PRIO_W = 3,
  parameter wq_src_kind_e KIND   = SRC_GENERAL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              en,
  input  logic [PRIO_W-1:0] prio,
  input  logic              cpu_mask,
  input  logic [PRIO_W-1:0] isr_level,
  input  logic              pseudo,
  output logic              ok
);
  logic eligible;
  logic kind_gate;

  // Mask, enable, nonzero level and nesting rule apply to every source type.
  assign eligible = req && en && (prio != '0) && !cpu_mask && (prio > isr_level);

  generate
    if (KIND == SRC_TIMER) begin : g_timer
      assign kind_gate = 1'b0 & pseudo;
    end else if (KIND == SRC_TICK) begin : g_tick
      assign kind_gate = pseudo;
    end else begin : g_general
      assign kind_gate = 1'b1 | pseudo;
    end
  endgenerate

  assign ok = eligible && kind_gate;

  // R6: a qualifying source always has its enable set and a nonzero level
  p_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (en && req && prio != '0));
endmodule

// File: rtl/wq_qualify.sv
module wq_qualify
  import wake_qual_pkg::*;
#(
  parameter int               NSRC       = 8,
  parameter int               PRIO_W     = 3,
  parameter logic [NSRC-1:0]  TICK_MASK  = 8'b0001_0000,
  parameter logic [NSRC-1:0]  TIMER_MASK = 8'b0000_1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nmi_req,
  input  logic [NSRC-1:0]        src_req,
  input  logic [NSRC-1:0]        src_en,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic                   cpu_mask,
  input  logic [PRIO_W-1:0]      isr_level,
  input  logic                   pseudo,
  output logic                   any_wake
);
  logic [NSRC-1:0] src_ok;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam wq_src_kind_e K = TIMER_MASK[i] ? SRC_TIMER :
                                   (TICK_MASK[i] ? SRC_TICK : SRC_GENERAL);
      wq_src_filter #(.PRIO_W(PRIO_W), .KIND(K)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (src_req[i]),
        .en        (src_en[i]),
        .prio      (src_prio[i*PRIO_W +: PRIO_W]),
        .cpu_mask  (cpu_mask),
        .isr_level (isr_level),
        .pseudo    (pseudo),
        .ok        (src_ok[i])
      );
    end
  endgenerate

  assign any_wake = nmi_req || (|src_ok);

  // R8: timer-type sources never contribute a qualified event
  p_timer_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ok & TIMER_MASK) == '0);
endmodule

// File: rtl/wq_seq.sv
module wq_seq
  import wake_qual_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stop_kind,
  input  logic any_wake,
  output logic wake,
  output logic in_stop,
  output logic stop_pseudo
);
  wq_state_e state_q;
  logic      kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      kind_q  <= 1'b0;
      wake    <= 1'b0;
    end else begin
      wake <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (stop_req && !any_wake) begin
            state_q <= ST_STOP;
            kind_q  <= stop_kind;
          end
        end
        ST_STOP: begin
          if (any_wake) begin
            state_q <= ST_RUN;
            kind_q  <= 1'b0;
            wake    <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign in_stop     = (state_q == ST_STOP);
  assign stop_pseudo = in_stop && kind_q;

  // R9: wake lasts exactly one cycle
  p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R9: wake coincides with the fall of the stop indicator
  p_wake_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> (!in_stop && $past(in_stop)));
  // R2: stop request with nothing pending enters stop
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stop && stop_req && !any_wake) |=> (in_stop && stop_pseudo == $past(stop_kind)));
  // R10: pending qualified event skips the stop state
  p_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stop && any_wake) |=> (!in_stop && !wake));
endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
  import wake_qual_pkg::*;
#(
  parameter int              NSRC       = 8,
  parameter int              PRIO_W     = 3,
  parameter logic [NSRC-1:0] TICK_MASK  = 8'b0001_0000,
  parameter logic [NSRC-1:0] TIMER_MASK = 8'b0000_1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_req,
  input  logic                   stop_kind,
  input  logic                   nmi_req,
  input  logic [NSRC-1:0]        src_req,
  input  logic [NSRC-1:0]        src_en,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic                   cpu_mask,
  input  logic [PRIO_W-1:0]      isr_level,
  output logic                   wake,
  output logic                   in_stop,
  output logic                   stop_pseudo
);
  logic any_wake;
  logic pseudo_eff;

  // In run state the requested kind governs the skip decision.
  assign pseudo_eff = in_stop ? stop_pseudo : stop_kind;

  wq_qualify #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .TICK_MASK(TICK_MASK), .TIMER_MASK(TIMER_MASK)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_req   (nmi_req),
    .src_req   (src_req),
    .src_en    (src_en),
    .src_prio  (src_prio),
    .cpu_mask  (cpu_mask),
    .isr_level (isr_level),
    .pseudo    (pseudo_eff),
    .any_wake  (any_wake)
  );

  wq_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .stop_kind   (stop_kind),
    .any_wake    (any_wake),
    .wake        (wake),
    .in_stop     (in_stop),
    .stop_pseudo (stop_pseudo)
  );

  // R3: non-maskable request always ends a stop
  p_nmi_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && nmi_req) |=> (wake && !in_stop));
  // R4: with the mask bit set only the non-maskable request can wake
  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && cpu_mask && !nmi_req) |=> (!wake && in_stop));
endmodule

// File: tb/wake_qualifier_tb.sv
module wake_qualifier_tb;
  localparam int NSRC = 8;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, stop_kind = 1'b0, nmi_req = 1'b0, cpu_mask = 1'b0;
  logic [NSRC-1:0] src_req = '0, src_en = '0;
  logic [NSRC*PW-1:0] src_prio = '0;
  logic [PW-1:0] isr_level = '0;
  logic wake, in_stop, stop_pseudo;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_kind(stop_kind),
    .nmi_req(nmi_req), .src_req(src_req), .src_en(src_en), .src_prio(src_prio),
    .cpu_mask(cpu_mask), .isr_level(isr_level),
    .wake(wake), .in_stop(in_stop), .stop_pseudo(stop_pseudo)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_inputs();
    stop_req = 0; nmi_req = 0; cpu_mask = 0; src_req = '0; src_en = '0;
    src_prio = '0; isr_level = '0;
  endtask

  task automatic enter_stop(input logic kind, input string tag);
    stop_kind = kind; stop_req = 1; step(); stop_req = 0;
    chk(in_stop, 1'b1, {tag, " in_stop"});
    chk(stop_pseudo, kind, {tag, " stop_pseudo"});
  endtask

  task automatic exit_nmi(input string tag);
    src_req = '0; nmi_req = 1; step(); nmi_req = 0;
    chk(wake, 1'b1, {tag, " wake"});
    chk(in_stop, 1'b0, {tag, " in_stop"});
    step();
    chk(wake, 1'b0, {tag, " wake drop"});
  endtask

  task automatic hold_blocked(input string tag);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(wake, 1'b0, {tag, " wake"});
      chk(in_stop, 1'b1, {tag, " in_stop"});
    end
  endtask

  task automatic t_reset();
    chk(in_stop, 1'b0, "R1 in_stop");
    chk(wake, 1'b0, "R1 wake");
    chk(stop_pseudo, 1'b0, "R1 stop_pseudo");
  endtask

  task automatic t_enter();
    enter_stop(1'b0, "R2 full");
    stop_kind = 1; stop_req = 1; step(); stop_req = 0;
    chk(stop_pseudo, 1'b0, "R2 repeat stop_req ignored");
    chk(in_stop, 1'b1, "R2 still stopped");
    exit_nmi("R3 full");
    enter_stop(1'b1, "R2 pseudo");
    cpu_mask = 1; src_en = '1; src_prio = '1;
    exit_nmi("R3 pseudo with mask");
    clear_inputs();
  endtask

  task automatic t_wake_pulse();
    enter_stop(1'b1, "R9 setup");
    src_en[0] = 1; src_prio[0 +: PW] = 3'd2; src_req[0] = 1; step();
    chk(wake, 1'b1, "R9 wake high");
    chk(in_stop, 1'b0, "R9 in_stop same edge");
    chk(stop_pseudo, 1'b0, "R9 stop_pseudo same edge");
    step();
    chk(wake, 1'b0, "R9 single cycle");
    clear_inputs();
  endtask

  task automatic t_mask();
    enter_stop(1'b1, "R4 setup");
    cpu_mask = 1; src_en[1] = 1; src_prio[1*PW +: PW] = 3'd7; src_req[1] = 1;
    hold_blocked("R4 masked");
    cpu_mask = 0; step();
    chk(wake, 1'b1, "R4 unmasked wake");
    clear_inputs(); step();
  endtask

  task automatic t_level();
    enter_stop(1'b0, "R5 setup");
    isr_level = 3'd3; src_en[2] = 1; src_prio[2*PW +: PW] = 3'd3; src_req[2] = 1;
    hold_blocked("R5 equal level");
    src_prio[2*PW +: PW] = 3'd4; step();
    chk(wake, 1'b1, "R5 higher level wakes");
    clear_inputs(); step();
  endtask

  task automatic t_enable();
    enter_stop(1'b1, "R6 setup");
    src_en[5] = 0; src_prio[5*PW +: PW] = 3'd5; src_req[5] = 1;
    hold_blocked("R6 disabled");
    src_en[5] = 1; src_prio[5*PW +: PW] = 3'd0;
    hold_blocked("R6 prio zero");
    exit_nmi("R6 release");
    clear_inputs();
  endtask

  task automatic t_tick();
    enter_stop(1'b0, "R7 setup full");
    src_en[4] = 1; src_prio[4*PW +: PW] = 3'd5; src_req[4] = 1;
    hold_blocked("R7 tick in full stop");
    exit_nmi("R7 release");
    src_en[4] = 1; src_prio[4*PW +: PW] = 3'd5;
    enter_stop(1'b1, "R7 setup pseudo");
    src_req[4] = 1; step();
    chk(wake, 1'b1, "R7 tick wakes pseudo");
    clear_inputs(); step();
  endtask

  task automatic t_timer();
    src_en[3] = 1; src_prio[3*PW +: PW] = 3'd7; src_req[3] = 1;
    enter_stop(1'b1, "R8 pending timer does not skip");
    hold_blocked("R8 timer");
    exit_nmi("R8 release");
    clear_inputs();
  endtask

  task automatic t_skip();
    src_en[6] = 1; src_prio[6*PW +: PW] = 3'd1; src_req[6] = 1;
    stop_kind = 0; stop_req = 1; step(); stop_req = 0;
    chk(in_stop, 1'b0, "R10 skip in_stop");
    chk(wake, 1'b0, "R10 skip no wake");
    step();
    chk(in_stop, 1'b0, "R10 skip stays run");
    chk(wake, 1'b0, "R10 skip still no wake");
    clear_inputs();
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_enter();
    t_wake_pulse();
    t_mask();
    t_level();
    t_enable();
    t_tick();
    t_timer();
    t_skip();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule